// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block is the instruction-fetch half of a bus interface. It keeps a code segment register and an instruction offset. From the two it forms a physical byte address: the segment is shifted left four places and the offset is added. It reads instruction bytes through a single-outstanding request/acknowledge memory port and parks them in a six-byte first-in first-out queue. A consumer drains the queue through a byte-wide valid/ready interface, and fetching continues while the consumer takes bytes.

A flush command replaces the segment and offset in one cycle and empties the queue. A read that was already in flight when the flush came still completes on the memory side, but the byte it returns is dropped. Fetching then resumes at the new location. Reset empties the queue and starts fetching from a segment and offset set by parameters.

Memory port protocol: `mem_req` rises together with a valid `mem_addr`. Both stay unchanged until a clock edge at which `mem_ack` is high. At that edge `mem_rdata` is captured.

Top module: `seg_prefetch_unit`

## Requirements
- R1: The queue never holds more than 6 bytes. A memory request is raised only when a queue slot is free to receive its byte, so a stalled consumer with a fast memory fills the queue to exactly 6 and leaves `mem_req` low.
- R2: Bytes reach `out_byte` in the order their requests were issued. The head byte stays unchanged while `out_valid` is high and `out_ready` is low.
- R3: The fetch address is (segment << 4) + offset, taken to 20 bits. Segment 2000h with offset 1234h requests address 21234h.
- R4: A sum above FFFFFh wraps modulo 2^20. Segment FFFFh with offset 0010h requests address 00000h.
- R5: The offset advances by one for each byte accepted into the queue and wraps modulo 2^16 inside the segment. Segment F000h at offset FFFFh requests FFFFFh and then F0000h.
- R6: At most one request is outstanding. `mem_req` stays high with `mem_addr` unchanged until the acknowledge edge.
- R7: When space remains, a new request is presented in the cycle right after an acknowledge, so a fast memory streams one byte per cycle.
- R8: `out_valid` is high exactly when the queue is non-empty. A byte leaves on each edge where `out_valid` and `out_ready` are both high, including edges where a byte also arrives.
- R9: When `flush_req` is high at an edge, the queue is empty after that edge, the segment and offset take `flush_seg` and `flush_ofs`, and the next request uses that address.
- R10: The byte returned for a request that was outstanding at a flush is discarded and never reaches the output.
- R11: While reset is low, `out_valid` and `mem_req` are low. The first request after reset uses segment FFFFh, offset 0000h, which is address FFFF0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_req | input | 1 | Empty the queue and reload segment and offset |
| flush_seg | input | 16 | New code segment value |
| flush_ofs | input | 16 | New instruction offset |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 20 | Physical byte address of the request |
| mem_ack | input | 1 | Read acknowledge, data valid this edge |
| mem_rdata | input | 8 | Returned instruction byte |
| out_valid | output | 1 | Queue head holds a byte |
| out_byte | output | 8 | Queue head byte |
| out_ready | input | 1 | Consumer takes the head byte |

## Verification
Random acknowledge latency combined with random consumer readiness tests queue order and occupancy under fill, drain and simultaneous push-and-pop. A reference queue fed by an address-derived memory pattern would expose a lost, repeated or misordered byte. Directed flushes to chosen segment:offset pairs separate correct address forming from its two wrap cases: the 20-bit sum wrap and the 16-bit offset wrap. A flush issued while a read is still waiting checks that a late byte is dropped rather than queued. A consumer held off against an always-ready memory checks that the slot reservation stops requests at exactly six bytes.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

   // fetch sequencer: no read in flight, a live read, or a read whose data is to be dropped
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_LIVE  = 2'd1,
      SEQ_STALE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/cfu_addr_gen.sv
module cfu_addr_gen #(
   parameter int SEG_W = 16,
   parameter int OFS_W = 16,
   parameter int SHIFT = 4,
   parameter int PA_W  = 20
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFS_W-1:0] ofs,
   output logic [PA_W-1:0]  pa
);

   localparam int BASE_W = SEG_W + SHIFT;

   logic [PA_W-1:0] base;

   // when the shifted segment is wider than the bus, upper bits fall away (modulo 2^PA_W)
   generate
      if (BASE_W > PA_W) begin : g_trunc
         logic [BASE_W-1:0] wide;
         assign wide = BASE_W'(seg) << SHIFT;
         assign base = wide[PA_W-1:0];
      end else begin : g_ext
         assign base = PA_W'(seg) << SHIFT;
      end
   endgenerate

   assign pa = base + PA_W'(ofs);

endmodule

// File: rtl/cfu_byte_queue.sv
module cfu_byte_queue #(
   parameter int DEPTH  = 6,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              nonempty,
   output logic [CNT_W-1:0]  count
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DATA_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nx, rd_nx;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nx = wr_ptr + PTR_W'(1);
         assign rd_nx = rd_ptr + PTR_W'(1);
      end else begin : g_mod
         assign wr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) slots[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nx;
         if (pop)  rd_ptr <= rd_nx;
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign head     = slots[rd_ptr];
   assign nonempty = (count != '0);

endmodule

// File: rtl/cfu_fetch_seq.sv
module cfu_fetch_seq
   import cfu_pkg::*;
#(
   parameter int          SEG_W     = 16,
   parameter int          OFS_W     = 16,
   parameter int          SHIFT     = 4,
   parameter int          PA_W      = 20,
   parameter int          DEPTH     = 6,
   parameter int          CNT_W     = 3,
   parameter int unsigned RESET_SEG = 32'hFFFF,
   parameter int unsigned RESET_OFS = 32'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [SEG_W-1:0] flush_seg,
   input  logic [OFS_W-1:0] flush_ofs,
   input  logic             mem_ack,
   input  logic [CNT_W-1:0] q_count,
   input  logic             pop,
   output logic             push,
   output logic             mem_req,
   output logic [PA_W-1:0]  mem_addr
);

   seq_state_e       state;
   logic [SEG_W-1:0] seg_q;
   logic [OFS_W-1:0] ofs_q;
   logic [OFS_W-1:0] ofs_adv;
   logic [PA_W-1:0]  req_addr_q;
   logic [PA_W-1:0]  next_pa;
   logic [CNT_W:0]   occ_after;
   logic             acked, slot_open, issue;

   assign acked     = (state != SEQ_IDLE) && mem_ack;
   assign push      = (state == SEQ_LIVE) && mem_ack && !flush;
   assign ofs_adv   = ofs_q + OFS_W'(push);
   assign occ_after = {1'b0, q_count} + (CNT_W+1)'(push) - (CNT_W+1)'(pop);
   assign slot_open = (state == SEQ_IDLE) || acked;
   assign issue     = slot_open && !flush && (occ_after < (CNT_W+1)'(DEPTH));

   cfu_addr_gen #(
      .SEG_W (SEG_W),
      .OFS_W (OFS_W),
      .SHIFT (SHIFT),
      .PA_W  (PA_W)
   ) u_agen (
      .seg (seg_q),
      .ofs (ofs_adv),
      .pa  (next_pa)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         seg_q      <= SEG_W'(RESET_SEG);
         ofs_q      <= OFS_W'(RESET_OFS);
         req_addr_q <= '0;
      end else if (flush) begin
         seg_q <= flush_seg;
         ofs_q <= flush_ofs;
         state <= (state != SEQ_IDLE && !mem_ack) ? SEQ_STALE : SEQ_IDLE;
      end else begin
         ofs_q <= ofs_adv;
         if (issue) begin
            state      <= SEQ_LIVE;
            req_addr_q <= next_pa;
         end else if (acked) begin
            state <= SEQ_IDLE;
         end
      end
   end

   assign mem_req  = (state != SEQ_IDLE);
   assign mem_addr = req_addr_q;

endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit #(
   parameter int          SEG_W     = 16,
   parameter int          OFS_W     = 16,
   parameter int          SHIFT     = 4,
   parameter int          PA_W      = 20,
   parameter int          DEPTH     = 6,
   parameter int          DATA_W    = 8,
   parameter int unsigned RESET_SEG = 32'hFFFF,
   parameter int unsigned RESET_OFS = 32'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_req,
   input  logic [SEG_W-1:0]  flush_seg,
   input  logic [OFS_W-1:0]  flush_ofs,
   output logic              mem_req,
   output logic [PA_W-1:0]   mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_byte,
   input  logic              out_ready
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("seg_prefetch_unit: DEPTH must be at least 2");
      end
      if (SHIFT < 1) begin : g_bad_shift
         $error("seg_prefetch_unit: SHIFT must be at least 1");
      end
      if (OFS_W > PA_W || SEG_W > PA_W) begin : g_bad_width
         $error("seg_prefetch_unit: segment and offset must fit the physical address");
      end
   endgenerate

   logic             push, pop;
   logic [CNT_W-1:0] q_count;

   assign pop = out_valid && out_ready && !flush_req;

   cfu_fetch_seq #(
      .SEG_W     (SEG_W),
      .OFS_W     (OFS_W),
      .SHIFT     (SHIFT),
      .PA_W      (PA_W),
      .DEPTH     (DEPTH),
      .CNT_W     (CNT_W),
      .RESET_SEG (RESET_SEG),
      .RESET_OFS (RESET_OFS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_req),
      .flush_seg (flush_seg),
      .flush_ofs (flush_ofs),
      .mem_ack   (mem_ack),
      .q_count   (q_count),
      .pop       (pop),
      .push      (push),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr)
   );

   cfu_byte_queue #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_req),
      .push      (push),
      .push_data (mem_rdata),
      .pop       (pop),
      .head      (out_byte),
      .nonempty  (out_valid),
      .count     (q_count)
   );

endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
   parameter int DEPTH  = 6,
   parameter int PA_W   = 20,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_req,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [PA_W-1:0]   mem_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_byte,
   input logic [CNT_W-1:0]  q_count
);

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CNT_W'(DEPTH));

   assert_slot_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (q_count < CNT_W'(DEPTH)));

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush_req) |=> (out_valid && $stable(out_byte)));

   assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> !out_valid);

   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |=> (!mem_req && !out_valid));

endmodule

bind seg_prefetch_unit cfu_checker #(
   .DEPTH  (DEPTH),
   .PA_W   (PA_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush_req (flush_req),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_byte  (out_byte),
   .q_count   (q_count)
);

// File: tb/seg_prefetch_unit_bench.sv
module seg_prefetch_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_req = 1'b0;
   logic [15:0] flush_seg = '0;
   logic [15:0] flush_ofs = '0;
   logic        mem_req;
   logic [19:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        out_valid;
   logic [7:0]  out_byte;
   logic        out_ready = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench reference state
   logic [7:0]  mq[$];
   logic [15:0] exp_seg = 16'hFFFF;
   logic [15:0] exp_ofs = 16'h0000;
   bit          outstanding = 1'b0;
   bit          cur_stale = 1'b0;
   logic [19:0] cur_addr = '0;
   string       addr_tag = "R11";

   always #5 clk = ~clk;

   seg_prefetch_unit u_seg_prefetch_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_req (flush_req),
      .flush_seg (flush_seg),
      .flush_ofs (flush_ofs),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .out_valid (out_valid),
      .out_byte  (out_byte),
      .out_ready (out_ready)
   );

   function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
      return {s, 4'h0} + {4'h0, o};
   endfunction

   function automatic logic [7:0] mem_byte(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5} ^ 8'h3C;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // called at a falling edge: check outputs, drive inputs, advance reference, move to next falling edge
   task automatic cyc(input bit ack, input bit rdy, input bit fl,
                      input logic [15:0] s, input logic [15:0] o);
      bit a;
      logic [7:0] e;
      check(out_valid == (mq.size() != 0), "R8", "out_valid vs occupancy",
            32'(out_valid), 32'(mq.size() != 0));
      check(mq.size() <= 6, "R1", "occupancy bound", 32'(mq.size()), 32'd6);
      if (outstanding && !mem_req)
         check(1'b0, "R6", "request dropped before acknowledge", 32'(mem_req), 32'd1);
      if (mem_req && !outstanding) begin
         check(mem_addr == phys(exp_seg, exp_ofs), addr_tag, "fetch address",
               32'(mem_addr), 32'(phys(exp_seg, exp_ofs)));
         addr_tag    = "R5";
         outstanding = 1'b1;
         cur_stale   = 1'b0;
         cur_addr    = mem_addr;
      end
      a         = ack && mem_req;
      mem_ack   = a;
      mem_rdata = mem_byte(mem_addr);
      out_ready = rdy;
      flush_req = fl;
      flush_seg = s;
      flush_ofs = o;
      if (out_valid && rdy && !fl) begin
         e = mq.pop_front();
         check(out_byte == e, "R2", "dequeued byte", 32'(out_byte), 32'(e));
      end
      if (a) begin
         outstanding = 1'b0;
         if (!cur_stale && !fl) begin
            mq.push_back(mem_byte(cur_addr));
            exp_ofs = exp_ofs + 16'd1;
         end
      end else if (fl && outstanding) begin
         cur_stale = 1'b1;
      end
      if (fl) begin
         mq.delete();
         exp_seg = s;
         exp_ofs = o;
      end
      @(negedge clk);
      mem_ack   = 1'b0;
      flush_req = 1'b0;
   endtask

   task automatic wait_fresh_req();
      for (int i = 0; i < 50; i++) begin
         if (mem_req && !outstanding) return;
         cyc(outstanding, 1'b1, 1'b0, 16'h0, 16'h0);
      end
      check(1'b0, "R9", "no fresh request", 32'(mem_req), 32'd1);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R11: quiet during reset
      check(mem_req == 1'b0, "R11", "mem_req in reset", 32'(mem_req), 32'd0);
      check(out_valid == 1'b0, "R11", "out_valid in reset", 32'(out_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_req && mem_addr == 20'hFFFF0, "R11", "first address after reset",
            32'(mem_addr), 32'hFFFF0);
      addr_tag = "R11";
      for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0);

      // R3: nominal address forming
      addr_tag = "R3";
      cyc(1'b0, 1'b1, 1'b1, 16'h2000, 16'h1234);
      check(out_valid == 1'b0, "R9", "queue empty after flush", 32'(out_valid), 32'd0);
      wait_fresh_req();
      check(mem_addr == 20'h21234, "R3", "2000:1234", 32'(mem_addr), 32'h21234);
      addr_tag = "R3";

      // R7: back-to-back requests with an always-ready memory
      cyc(1'b0, 1'b1, 1'b0, 16'h0, 16'h0);
      cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0);
      check(mem_req == 1'b1 && !outstanding, "R7", "request right after acknowledge",
            32'(mem_req), 32'd1);
      check(mem_addr == 20'h21235, "R7", "streamed address", 32'(mem_addr), 32'h21235);
      for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0);

      // R4: 20-bit wrap
      addr_tag = "R4";
      cyc(1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h0010);
      wait_fresh_req();
      check(mem_addr == 20'h00000, "R4", "FFFF:0010", 32'(mem_addr), 32'h0);
      addr_tag = "R4";
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0);

      // R5: offset wrap inside the segment
      addr_tag = "R5";
      cyc(1'b0, 1'b1, 1'b1, 16'hF000, 16'hFFFF);
      wait_fresh_req();
      check(mem_addr == 20'hFFFFF, "R5", "F000:FFFF", 32'(mem_addr), 32'hFFFFF);
      cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0);
      check(mem_req && mem_addr == 20'hF0000, "R5", "offset wrapped to F000:0000",
            32'(mem_addr), 32'hF0000);

      // R1: stalled consumer fills the queue to six and stops requesting
      for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
      check(out_valid == 1'b1 && mq.size() == 6, "R1", "queue full", 32'(mq.size()), 32'd6);
      check(mem_req == 1'b0, "R1", "no request when full", 32'(mem_req), 32'd0);
      // R8: drain with simultaneous arrivals
      for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0);

      // R10: flush while a read is waiting, late byte dropped
      wait_fresh_req();
      cyc(1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
      cyc(1'b0, 1'b0, 1'b1, 16'h3000, 16'h0000);
      check(mem_req == 1'b1, "R10", "stale read still held", 32'(mem_req), 32'd1);
      addr_tag = "R9";
      cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0);
      check(out_valid == 1'b0, "R10", "stale byte discarded", 32'(out_valid), 32'd0);
      check(mem_req && mem_addr == 20'h30000, "R9", "restart at new address",
            32'(mem_addr), 32'h30000);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] rs, ro;
         bit fl;
         fl = ($urandom % 60) == 0;
         rs = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
         ro = (($urandom % 4) == 0) ? 16'hFFFD : 16'($urandom);
         cyc(($urandom % 3) != 0, ($urandom % 4) != 0, fl, rs, ro);
      end
      for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R6 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule